// File: doc/BRIEF.md
# Converter Serial Result Port

This block is the slave-side serial read path of a sampling converter. It keeps a 16-bit conversion result in a shift register and presents it one bit at a time on `sdout`, MSB first. The host supplies the serial clock, and that clock only has an effect while both `cs_n` and `rd_n` are low. Every serial input is brought into the `clk` domain through a synchronizer. Edges of `sclk` are then detected by oversampling, so `sclk` must stay well below the system clock rate.

Two read modes are selected by `mode`:

- **Mode 0 (read after conversion).** The word is read once `busy` has dropped. A daisy-chain input `sdin` is captured on the rising `sclk` edge and enters the LSB end on the next falling edge. Data from an upstream part therefore follows the local LSB directly.
- **Mode 1 (read during conversion).** The previous result is read while `busy` is high. A read that is still unfinished when `busy` falls produces a one-cycle `rderror` pulse.

Top module: `conv_result_serializer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sdout` and `rderror` are both low.
- R2: On a falling edge of `busy`, `result` is loaded. In mode 1 this always happens. In mode 0 it happens only when no partial read is open. After the load, the MSB of the loaded word appears on `sdout` before any serial clock edge.
- R3: Each gated falling edge of `sclk` advances `sdout` by one bit, MSB first, so 16 falling edges present all 16 bits. Rising edges never advance the word.
- R4: `sclk` edges that occur while `cs_n` is high or `rd_n` is high leave `sdout` unchanged.
- R5: In mode 0, shifting happens only while `busy` is low. Edges that occur while `busy` is high leave `sdout` unchanged.
- R6: In mode 0, `sdin` is sampled on each gated rising edge and inserted at the LSB on the following falling edge. After the local 16 bits, `sdout` carries the upstream bits in the order they were sampled.
- R7: In mode 1, shifting happens only while `busy` is high. `sdin` is ignored, and zeros enter at the LSB.
- R8: In mode 1, if `busy` falls after 1 to 15 bits have been shifted, `rderror` is high for exactly one `clk` cycle. The partial read is dropped and the new word is loaded.
- R9: In mode 1, if `busy` falls after either 0 or all 16 bits have been shifted, no `rderror` pulse occurs.
- R10: In mode 0, a falling edge of `busy` during a partial read (1 to 15 bits) does not replace the word, and the read continues with the old bits. A rising edge of `cs_n` closes the read.
- R11: With a serial clock that idles high, the bit order is the same as with one that idles low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Host serial clock, asynchronous |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| busy | input | 1 | High while a conversion runs |
| sdin | input | 1 | Daisy-chain serial input from the upstream part |
| mode | input | 1 | 0: read after conversion, 1: read during conversion |
| result | input | DATA_W | Conversion result word, stable around the `busy` fall |
| sdout | output | 1 | Registered serial data out |
| rderror | output | 1 | One-cycle pulse when a read is left incomplete |

## Verification
The word is read with a clock idling low and with one idling high. Patterns chosen so that neighbouring bits differ expose any skipped or doubled shift, and these patterns separate falling-edge shifting from rising-edge shifting. Clock bursts sent with select or read-enable inactive, or in the wrong `busy` phase, must leave the MSB in place; this separates correct gating from leaky gating. A 32-clock chain read with a distinct upstream word separates proper pass-through from zero fill. In mode 1, reads of 0, 5 and 16 bits around the `busy` fall separate error flagging from a missed flag or a false one.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef enum logic {
    RD_AFTER_CONV  = 1'b0,
    RD_DURING_CONV = 1'b1
  } read_mode_e;
endpackage

// File: rtl/crs_sync.sv
// Multi-bit flop chain bringing asynchronous pins into the clk domain.
module crs_sync #(
  parameter int              WIDTH     = 1,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RESET_VAL;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/crs_ctrl.sv
// Edge detection, gating, bit counting and load/error decisions.
module crs_ctrl
  import crs_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk_s,
  input  logic       cs_n_s,
  input  logic       rd_n_s,
  input  logic       busy_s,
  input  read_mode_e mode_s,
  output logic       shift_o,
  output logic       capture_o,
  output logic       load_o,
  output logic       err_o,
  output logic       chain_en_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic             sclk_q, busy_q, cs_n_q;
  logic [CNT_W-1:0] cnt;
  logic             after_mode;
  logic             sclk_rise, sclk_fall, busy_fall, cs_rise;
  logic             phase_ok, gate, in_progress;

  assign after_mode = (mode_s == RD_AFTER_CONV);
  assign sclk_rise  = sclk_s & ~sclk_q;
  assign sclk_fall  = ~sclk_s & sclk_q;
  assign busy_fall  = ~busy_s & busy_q;
  assign cs_rise    = cs_n_s & ~cs_n_q;

  // mode 0 reads in the idle phase, mode 1 during the conversion
  assign phase_ok    = after_mode ? ~busy_s : busy_s;
  assign gate        = ~cs_n_s & ~rd_n_s & phase_ok;
  assign in_progress = (cnt != '0) && (cnt < FULL);

  always_comb begin
    shift_o    = gate & sclk_fall;
    capture_o  = gate & sclk_rise & after_mode;
    chain_en_o = after_mode;
    load_o     = busy_fall & (~in_progress | ~after_mode);
    err_o      = busy_fall & in_progress & ~after_mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
      cs_n_q <= 1'b1;
      cnt    <= '0;
    end else begin
      sclk_q <= sclk_s;
      busy_q <= busy_s;
      cs_n_q <= cs_n_s;
      if (load_o)                     cnt <= '0;
      else if (after_mode && cs_rise) cnt <= '0;
      else if (shift_o && cnt != FULL) cnt <= cnt + ONE;
    end
  end
endmodule

// File: rtl/crs_shifter.sv
// Result shift register with daisy-chain capture bit and registered output.
module crs_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              capture_i,
  input  logic              chain_en_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              sdin_i,
  output logic              sdout_o
);
  logic [DATA_W-1:0] sreg;
  logic              cap_q;
  logic              fill;

  assign fill = chain_en_i & cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg    <= '0;
      cap_q   <= 1'b0;
      sdout_o <= 1'b0;
    end else begin
      if (load_i) begin
        sreg  <= word_i;
        cap_q <= 1'b0;
      end else begin
        if (shift_i)   sreg  <= {sreg[DATA_W-2:0], fill};
        if (capture_i) cap_q <= sdin_i;
      end
      sdout_o <= sreg[DATA_W-1];
    end
  end
endmodule

// File: rtl/conv_result_serializer.sv
module conv_result_serializer
  import crs_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              busy,
  input  logic              sdin,
  input  logic              mode,
  input  logic [DATA_W-1:0] result,
  output logic              sdout,
  output logic              rderror
);
  localparam int         NPINS    = 6;
  localparam logic [5:0] PIN_RST  = 6'b000110; // rd_n and cs_n rest high

  logic [NPINS-1:0] pins_raw, pins_s;
  logic             sclk_s, cs_n_s, rd_n_s, busy_s, sdin_s;
  read_mode_e       mode_s;
  logic             shift_w, capture_w, load_w, err_w, chain_en_w;

  assign pins_raw = {mode, sdin, busy, rd_n, cs_n, sclk};

  crs_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES), .RESET_VAL(PIN_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_raw),
    .q   (pins_s)
  );

  assign sclk_s = pins_s[0];
  assign cs_n_s = pins_s[1];
  assign rd_n_s = pins_s[2];
  assign busy_s = pins_s[3];
  assign sdin_s = pins_s[4];
  assign mode_s = read_mode_e'(pins_s[5]);

  crs_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sclk_s     (sclk_s),
    .cs_n_s     (cs_n_s),
    .rd_n_s     (rd_n_s),
    .busy_s     (busy_s),
    .mode_s     (mode_s),
    .shift_o    (shift_w),
    .capture_o  (capture_w),
    .load_o     (load_w),
    .err_o      (err_w),
    .chain_en_o (chain_en_w)
  );

  crs_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_w),
    .shift_i    (shift_w),
    .capture_i  (capture_w),
    .chain_en_i (chain_en_w),
    .word_i     (result),
    .sdin_i     (sdin_s),
    .sdout_o    (sdout)
  );

  always_ff @(posedge clk) begin
    if (rst) rderror <= 1'b0;
    else     rderror <= err_w;
  end
endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              sdout,
  input logic              rderror,
  input logic [DATA_W-1:0] result,
  input logic              shift_pulse,
  input logic              load_pulse,
  input logic              cs_n_s,
  input logic              rd_n_s,
  input logic              busy_s,
  input logic              mode_s
);
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (!sdout && !rderror));

  p_load_msb_r2: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> ##1 (sdout == $past(result[DATA_W-1], 2)));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!shift_pulse && !load_pulse) |=> ##1 $stable(sdout));

  p_gated_r4: assert property (@(posedge clk) disable iff (rst)
    shift_pulse |-> (!cs_n_s && !rd_n_s));

  p_busy_phase_r5: assert property (@(posedge clk) disable iff (rst)
    shift_pulse |-> (busy_s == mode_s));

  p_err_single_r8: assert property (@(posedge clk) disable iff (rst)
    rderror |=> !rderror);

  p_err_mode_r8: assert property (@(posedge clk) disable iff (rst)
    rderror |-> ($past(mode_s) && $past(load_pulse)));
endmodule

bind conv_result_serializer crs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sdout       (sdout),
  .rderror     (rderror),
  .result      (result),
  .shift_pulse (shift_w),
  .load_pulse  (load_w),
  .cs_n_s      (cs_n_s),
  .rd_n_s      (rd_n_s),
  .busy_s      (busy_s),
  .mode_s      (mode_s)
);

// File: tb/sim_conv_result_serializer.sv
module sim_conv_result_serializer;
  localparam int W    = 16;
  localparam int HALF = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sclk = 1'b0, cs_n = 1'b1, rd_n = 1'b1, busy = 1'b0, sdin = 1'b0, mode = 1'b0;
  logic [W-1:0] result = '0;
  logic         sdout, rderror;

  int n_checks = 0;
  int n_fail   = 0;
  int err_pulses = 0;
  int err_run    = 0;
  int err_width  = 0;

  typedef struct {
    logic  val;
    string req;
  } exp_t;
  exp_t exp_q[$];
  event sample_ev;

  always #10 clk = ~clk;

  conv_result_serializer #(.DATA_W(W)) u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .rd_n(rd_n), .busy(busy),
    .sdin(sdin), .mode(mode), .result(result), .sdout(sdout), .rderror(rderror)
  );

  // rderror pulse monitor
  always @(posedge clk) begin
    if (rderror) err_run = err_run + 1;
    else if (err_run != 0) begin
      err_width  = err_run;
      err_pulses = err_pulses + 1;
      err_run    = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard monitor
  initial begin : monitor
    exp_t e;
    forever begin
      @(sample_ev);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check(e.req, int'(sdout), int'(e.val));
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_bit(input logic v, input string req);
    exp_t e;
    e.val = v;
    e.req = req;
    exp_q.push_back(e);
    -> sample_ev;
    wait_clk(1);
  endtask

  task automatic pulse_low_idle();
    sclk = 1'b1; wait_clk(HALF);
    sclk = 1'b0; wait_clk(HALF);
  endtask

  task automatic convert(input logic [W-1:0] w);
    result = w;
    busy = 1'b1; wait_clk(10);
    busy = 1'b0; wait_clk(10);
  endtask

  // read bits [first, first+n) of w; sdin driven from up when use_up
  task automatic read_bits(input logic [W-1:0] w, input int first, input int n,
                           input logic [W-1:0] up, input bit use_up, input string req);
    for (int i = first; i < first + n; i++) begin
      sdin = use_up ? up[W-1-i] : 1'b0;
      expect_bit(w[W-1-i], req);
      pulse_low_idle();
    end
    sdin = 1'b0;
  endtask

  task automatic select(input logic c, input logic r);
    cs_n = c; rd_n = r; wait_clk(6);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    int p0;
    wait_clk(5);
    check("R1 sdout in reset", int'(sdout), 0);
    check("R1 rderror in reset", int'(rderror), 0);
    rst = 1'b0;
    wait_clk(1);
    check("R1 sdout after reset", int'(sdout), 0);
    wait_clk(5);

    // mode 0 basic read, then zero fill from chain input (R2, R3, R6)
    convert(16'hA5C3);
    select(1'b0, 1'b0);
    read_bits(16'hA5C3, 0, W, '0, 1'b0, "R3 basic read");
    expect_bit(1'b0, "R6 zero chain fill");
    select(1'b1, 1'b1);

    // gating by select and read enable (R4)
    convert(16'h8001);
    select(1'b1, 1'b0);
    repeat (3) pulse_low_idle();
    check("R4 cs_n high ignores sclk", int'(sdout), 1);
    select(1'b0, 1'b1);
    repeat (3) pulse_low_idle();
    check("R4 rd_n high ignores sclk", int'(sdout), 1);
    select(1'b0, 1'b0);
    read_bits(16'h8001, 0, W, '0, 1'b0, "R2 load then R4 full read");
    select(1'b1, 1'b1);

    // mode 0: edges during busy high ignored (R5)
    convert(16'h4000);
    select(1'b0, 1'b0);
    busy = 1'b1; wait_clk(6);
    repeat (2) pulse_low_idle();
    check("R5 no shift while busy high", int'(sdout), 0);
    busy = 1'b0; wait_clk(10);
    read_bits(16'h4000, 0, W, '0, 1'b0, "R5 read after busy low");
    select(1'b1, 1'b1);

    // daisy chain: local word then upstream word (R6)
    convert(16'h1234);
    select(1'b0, 1'b0);
    read_bits(16'h1234, 0, W, 16'hBEEF, 1'b1, "R6 local part");
    read_bits(16'hBEEF, 0, W, '0, 1'b0, "R6 upstream part");
    select(1'b1, 1'b1);

    // mode 0: busy fall mid-read keeps old word (R10)
    convert(16'hF00F);
    select(1'b0, 1'b0);
    read_bits(16'hF00F, 0, 4, '0, 1'b0, "R10 first bits");
    result = 16'h0FF0;
    busy = 1'b1; wait_clk(10);
    busy = 1'b0; wait_clk(10);
    read_bits(16'hF00F, 4, W - 4, '0, 1'b0, "R10 old word continues");
    select(1'b1, 1'b1);

    // mode 1: read during conversion, full read (R7, R9)
    mode = 1'b1; wait_clk(6);
    convert(16'h3C5A);
    busy = 1'b1; wait_clk(6);
    result = 16'h9999;
    select(1'b0, 1'b0);
    read_bits(16'h3C5A, 0, W, 16'hFFFF, 1'b1, "R7 read during busy");
    expect_bit(1'b0, "R7 sdin ignored, zero fill");
    p0 = err_pulses;
    busy = 1'b0; wait_clk(10);
    check("R9 no error after full read", err_pulses, p0);
    check("R2 new word MSB after busy fall", int'(sdout), 1);
    repeat (2) pulse_low_idle();
    check("R7 no shift while busy low", int'(sdout), 1);

    // mode 1: partial read flagged (R8)
    busy = 1'b1; wait_clk(6);
    result = 16'h6E21;
    read_bits(16'h9999, 0, 5, '0, 1'b0, "R8 partial read");
    busy = 1'b0; wait_clk(10);
    check("R8 one error pulse", err_pulses, p0 + 1);
    check("R8 pulse width one cycle", err_width, 1);
    check("R8 new word loaded", int'(sdout), 0);
    busy = 1'b1; wait_clk(6);
    result = 16'h1111;
    read_bits(16'h6E21, 0, W, '0, 1'b0, "R8 word after abandoned read");
    busy = 1'b0; wait_clk(10);
    check("R9 no error after full read", err_pulses, p0 + 1);

    // mode 1: conversion with no read at all (R9)
    busy = 1'b1; wait_clk(10);
    busy = 1'b0; wait_clk(10);
    check("R9 no error without read", err_pulses, p0 + 1);
    select(1'b1, 1'b1);

    // idle-high serial clock in mode 0 (R11)
    mode = 1'b0; wait_clk(6);
    convert(16'hC7E1);
    sclk = 1'b1; wait_clk(HALF);
    select(1'b0, 1'b0);
    for (int i = 0; i < W; i++) begin
      expect_bit(result[W-1-i], "R11 idle-high clock order");
      sclk = 1'b0; wait_clk(HALF);
      sclk = 1'b1; wait_clk(HALF);
    end
    select(1'b1, 1'b1);
    check("R1 rderror quiet at end", int'(rderror), 0);

    wait_clk(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule